// File: doc/BRIEF.md
# Authenticated cipher state core

This block holds the 640-bit working state of a round-function based authenticated cipher. The state is split into five 128-bit words. One update step runs a keyless AES round on every word in parallel. Each round result is XORed into the next word along a ring, and a 128-bit message word is folded into the first word. A start pulse latches a key and an IV, loads the state from them and from two fixed constants, and then runs a fixed schedule of ten update steps.

After initialization the core accepts one message word per accepted valid/ready handshake. Each accepted word costs one clock cycle. A one-cycle done pulse marks the end of initialization and the end of every absorb step. The full state is always visible on a flat read port, so the surrounding logic can derive keystream or tag material from it.

Top module: `ae_state_core`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises: state_o is all zero, done_o is low and msg_ready_o is high (as long as start_i is low).
- R2: Word w occupies state_o[128*w +: 128], and byte i of a word occupies bits [8*i +: 8]. The round R(x) does three things with no key addition. First, output byte i takes input byte (5*i) mod 16. Second, every byte passes through the S-box. Third, each 4-byte column (bytes 4c..4c+3) is mixed with the AES MixColumns matrix, using doubling by shift-left with 0x1B reduction.
- R3: One update with message word M sets S0 to S0^R(S4)^M and sets Sw to Sw^R(Sw-1) for w = 1..4. Every term uses the values from before the step.
- R4: The S-box is the standard AES substitution (for example 0x00 maps to 0x63 and 0x53 maps to 0xED).
- R5: In the cycle after an accepted start, the state holds S0=K^IV, S1=B, S2=A, S3=K^A, S4=K^B. A is bytes 0..15 = 00 01 01 02 03 05 08 0d 15 22 37 59 90 e9 79 62. B is bytes 0..15 = db 3d 18 55 6d c2 2f f1 20 11 31 42 73 b5 28 dd.
- R6: After the load, ten consecutive cycles each apply one update. The absorbed word alternates K, K^IV, K, ... starting with K. Key and IV are latched at start. msg_ready_o stays low from the load through the tenth step. A start_i pulse during this window has no effect.
- R7: When msg_valid_i and msg_ready_o are both high at a clock edge, exactly one update with msg_i is applied at that edge. With no accepted word and no start, state_o holds its value.
- R8: done_o is high for exactly the cycle following the tenth initialization step, and for the cycle following each accepted message word.
- R9: When start_i is high in an idle cycle, msg_ready_o is low and the load takes place instead of an absorb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin load and initialization |
| key_i | input | 128 | Key, sampled with start_i |
| iv_i | input | 128 | IV, sampled with start_i |
| msg_valid_i | input | 1 | Message word offered |
| msg_i | input | 128 | Message word to absorb |
| msg_ready_o | output | 1 | Core can absorb a word this cycle |
| done_o | output | 1 | One-cycle pulse after init end or absorb |
| state_o | output | 640 | Five state words, word 0 in the low bits |

## Verification
The bench builds the core with its default of five initialization pairs, which gives the ten-step schedule. With that setting, the exact load-to-done latency, the K/K^IV alternation order and the ready blackout window are all checked cycle by cycle. Because the width of the state and the round structure are fixed, a zero-state absorb of an all-zero word gives a known all-0x63 result that pins the S-box and the mixing independently of the model. Random keys, IVs and message streams then cover the chaining of rounds between neighbouring words.

// File: rtl/ae_state_pkg.sv
package ae_state_pkg;
  localparam int WORD_W  = 128;
  localparam int NWORDS  = 5;
  localparam int NBYTES  = WORD_W / 8;
  localparam int NCOLS   = NBYTES / 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NWORDS-1:0] state_t;

  // byte 0 in bits [7:0]
  localparam word_t CONST_A = 128'h6279e990_59372215_0d080503_02010100;
  localparam word_t CONST_B = 128'hdd28b573_42311120_f12fc26d_55183ddb;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = xtime(x);
    end
    return r;
  endfunction

  // a^254 is the field inverse, with 0 mapped to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction
endpackage

// File: rtl/ae_sbox.sv
module ae_sbox
  import ae_state_pkg::*;
(
  input  logic [7:0] a_i,
  output logic [7:0] s_o
);
  logic [7:0] inv;

  always_comb begin
    inv = gf_inv(a_i);
    s_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/ae_round.sv
module ae_round
  import ae_state_pkg::*;
(
  input  word_t d_i,
  output word_t q_o
);
  logic [NBYTES-1:0][7:0] sb;

  for (genvar i = 0; i < NBYTES; i++) begin : g_sub
    localparam int SRC = (i + 4 * (i % 4)) % NBYTES;
    ae_sbox u_sbox (.a_i(d_i[8*SRC +: 8]), .s_o(sb[i]));
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int B0 = 4*c + r;
      localparam int B1 = 4*c + (r+1) % 4;
      localparam int B2 = 4*c + (r+2) % 4;
      localparam int B3 = 4*c + (r+3) % 4;
      assign q_o[8*B0 +: 8] = xtime(sb[B0]) ^ xtime(sb[B1]) ^ sb[B1] ^ sb[B2] ^ sb[B3];
    end
  end
endmodule

// File: rtl/ae_update.sv
module ae_update
  import ae_state_pkg::*;
(
  input  state_t s_i,
  input  word_t  m_i,
  output state_t s_o
);
  state_t rnd;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    ae_round u_round (.d_i(s_i[w]), .q_o(rnd[w]));
    if (w == 0) begin : g_head
      assign s_o[w] = s_i[w] ^ rnd[NWORDS-1] ^ m_i;
    end else begin : g_chain
      assign s_o[w] = s_i[w] ^ rnd[w-1];
    end
  end
endmodule

// File: rtl/ae_ctrl.sv
module ae_ctrl #(
  parameter int INIT_STEPS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic msg_valid_i,
  output logic load_o,
  output logic absorb_o,
  output logic busy_o,
  output logic sel_kiv_o,
  output logic ready_o,
  output logic done_o
);
  localparam int CW = $clog2(INIT_STEPS + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last;

  assign ready_o   = !busy_q && !start_i;
  assign load_o    = start_i && !busy_q;
  assign absorb_o  = msg_valid_i && ready_o;
  assign busy_o    = busy_q;
  assign sel_kiv_o = cnt_q[0];
  assign done_o    = done_q;
  assign last      = busy_q && (cnt_q == CW'(INIT_STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last || absorb_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ae_state_core.sv
module ae_state_core
  import ae_state_pkg::*;
#(
  parameter int INIT_PAIRS = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [WORD_W-1:0]        key_i,
  input  logic [WORD_W-1:0]        iv_i,
  input  logic                     msg_valid_i,
  input  logic [WORD_W-1:0]        msg_i,
  output logic                     msg_ready_o,
  output logic                     done_o,
  output logic [NWORDS*WORD_W-1:0] state_o
);
  localparam int INIT_STEPS = 2 * INIT_PAIRS;

  logic   load, absorb, busy, sel_kiv;
  word_t  key_q, kiv_q, upd_msg;
  state_t state_q, state_nx;

  ae_ctrl #(.INIT_STEPS(INIT_STEPS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .msg_valid_i (msg_valid_i),
    .load_o      (load),
    .absorb_o    (absorb),
    .busy_o      (busy),
    .sel_kiv_o   (sel_kiv),
    .ready_o     (msg_ready_o),
    .done_o      (done_o)
  );

  assign upd_msg = busy ? (sel_kiv ? kiv_q : key_q) : msg_i;

  ae_update u_update (.s_i(state_q), .m_i(upd_msg), .s_o(state_nx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      key_q   <= '0;
      kiv_q   <= '0;
    end else if (load) begin
      key_q   <= key_i;
      kiv_q   <= key_i ^ iv_i;
      state_q <= {key_i ^ CONST_B, key_i ^ CONST_A, CONST_A, CONST_B, key_i ^ iv_i};
    end else if (busy || absorb) begin
      state_q <= state_nx;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/ae_state_core_chk.sv
module ae_state_core_chk #(
  parameter int INIT_STEPS = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         msg_valid_i,
  input logic         msg_ready_o,
  input logic         done_o,
  input logic         busy_i,
  input logic [639:0] state_o
);
  localparam int CW = $clog2(INIT_STEPS + 1) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= '0;
    else         busy_cnt <= busy_i ? busy_cnt + 1'b1 : '0;
  end

  AST_START_BLOCKS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> busy_i && !msg_ready_o); // R6

  AST_INIT_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_cnt == CW'(INIT_STEPS)); // R6

  AST_DONE_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_o); // R8

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_i) || $past(msg_valid_i && msg_ready_o)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !start_i && !(msg_valid_i && msg_ready_o) |=> $stable(state_o)); // R7

  AST_START_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !msg_ready_o); // R9
endmodule

bind ae_state_core ae_state_core_chk #(.INIT_STEPS(INIT_STEPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .msg_valid_i (msg_valid_i),
  .msg_ready_o (msg_ready_o),
  .done_o      (done_o),
  .busy_i      (busy),
  .state_o     (state_o)
);

// File: tb/ae_state_core_tb.sv
module ae_state_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] iv_i = '0;
  logic         msg_valid_i = 1'b0;
  logic [127:0] msg_i = '0;
  logic         msg_ready_o;
  logic         done_o;
  logic [639:0] state_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0]   sbox_t [256];
  logic [127:0] ref_s [5];

  ae_state_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .key_i(key_i), .iv_i(iv_i),
    .msg_valid_i(msg_valid_i), .msg_i(msg_i), .msg_ready_o(msg_ready_o),
    .done_o(done_o), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] b_dbl(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
  endfunction

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = b_dbl(x);
    end
    return r;
  endfunction

  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] o;
      for (int y = 1; y < 256; y++)
        if (v != 0 && b_mul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      sbox_t[v] = o ^ 8'h63;
    end
  endtask

  function automatic logic [127:0] b_round(input logic [127:0] w);
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) t[i] = sbox_t[w[8*((5*i)%16) +: 8]];
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
      o[8*(4*c)   +: 8] = b_mul(a0,8'h02) ^ b_mul(a1,8'h03) ^ a2 ^ a3;
      o[8*(4*c+1) +: 8] = a0 ^ b_mul(a1,8'h02) ^ b_mul(a2,8'h03) ^ a3;
      o[8*(4*c+2) +: 8] = a0 ^ a1 ^ b_mul(a2,8'h02) ^ b_mul(a3,8'h03);
      o[8*(4*c+3) +: 8] = b_mul(a0,8'h03) ^ a1 ^ a2 ^ b_mul(a3,8'h02);
    end
    return o;
  endfunction

  task automatic ref_upd(input logic [127:0] m);
    logic [127:0] o [5];
    o[0] = ref_s[0] ^ b_round(ref_s[4]) ^ m;
    for (int w = 1; w < 5; w++) o[w] = ref_s[w] ^ b_round(ref_s[w-1]);
    for (int w = 0; w < 5; w++) ref_s[w] = o[w];
  endtask

  task automatic ref_load(input logic [127:0] k, input logic [127:0] iv);
    logic [127:0] ca = {8'h62,8'h79,8'he9,8'h90,8'h59,8'h37,8'h22,8'h15,
                        8'h0d,8'h08,8'h05,8'h03,8'h02,8'h01,8'h01,8'h00};
    logic [127:0] cb = {8'hdd,8'h28,8'hb5,8'h73,8'h42,8'h31,8'h11,8'h20,
                        8'hf1,8'h2f,8'hc2,8'h6d,8'h55,8'h18,8'h3d,8'hdb};
    ref_s[0] = k ^ iv; ref_s[1] = cb; ref_s[2] = ca; ref_s[3] = k ^ ca; ref_s[4] = k ^ cb;
  endtask

  function automatic logic [639:0] ref_flat();
    return {ref_s[4], ref_s[3], ref_s[2], ref_s[1], ref_s[0]};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [639:0] act, input logic [639:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_init(input logic [127:0] k, input logic [127:0] iv, input bit glitch);
    key_i = k; iv_i = iv; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    ref_load(k, iv);
    chk(state_o == ref_flat(), "R5 load", state_o, ref_flat());
    chk(msg_ready_o == 1'b0, "R6 ready low at load", 640'(msg_ready_o), 640'(0));
    for (int s = 1; s <= 10; s++) begin
      tick();
      if (glitch && s == 4) start_i = 1'b0;
      if (s < 10) begin
        chk(done_o == 1'b0 && msg_ready_o == 1'b0, "R6/R8 busy window",
            640'({done_o, msg_ready_o}), 640'(0));
      end else begin
        chk(done_o == 1'b1, "R8 done after init", 640'(done_o), 640'(1));
        chk(msg_ready_o == 1'b1, "R6 ready after init", 640'(msg_ready_o), 640'(1));
      end
      if (glitch && s == 3) begin
        start_i = 1'b1; key_i = ~k;
      end
    end
    for (int p = 0; p < 5; p++) begin
      ref_upd(k); ref_upd(k ^ iv);
    end
    chk(state_o == ref_flat(), glitch ? "R6 init, start ignored" : "R6 init result",
        state_o, ref_flat());
  endtask

  task automatic do_absorb(input logic [127:0] m);
    msg_valid_i = 1'b1; msg_i = m;
    chk(msg_ready_o == 1'b1, "R7 ready idle", 640'(msg_ready_o), 640'(1));
    tick();
    msg_valid_i = 1'b0;
    ref_upd(m);
    chk(state_o == ref_flat(), "R3/R7 absorb", state_o, ref_flat());
    chk(done_o == 1'b1, "R8 done after absorb", 640'(done_o), 640'(1));
    tick();
    chk(done_o == 1'b0 && state_o == ref_flat(), "R7/R8 idle hold",
        {state_o[638:0], done_o}, {ref_s[4][126:0], ref_s[3], ref_s[2], ref_s[1], ref_s[0], 1'b0});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] k, iv, m;
    void'($urandom(32'd2024));
    build_sbox();
    chk(sbox_t[8'h00] == 8'h63 && sbox_t[8'h53] == 8'hed && sbox_t[8'h01] == 8'h7c,
        "R4 model sbox", 640'({sbox_t[8'h00], sbox_t[8'h53]}), 640'(16'h63ed));
    @(negedge clk); @(negedge clk);
    chk(state_o == '0 && done_o == 1'b0, "R1 in reset", state_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(state_o == '0 && done_o == 1'b0 && msg_ready_o == 1'b1, "R1 after reset",
        640'({done_o, msg_ready_o}), 640'(1));

    // zero state absorbing zero gives 0x63 in every byte
    for (int w = 0; w < 5; w++) ref_s[w] = '0;
    msg_valid_i = 1'b1; msg_i = '0;
    tick();
    msg_valid_i = 1'b0;
    chk(state_o == {80{8'h63}}, "R2/R4 zero-state round", state_o, {80{8'h63}});
    ref_upd('0);
    tick();
    do_absorb({128{1'b1}});
    do_absorb(rnd128());

    do_init('0, '0, 1'b0);
    for (int t = 0; t < 3; t++) do_absorb(rnd128());
    for (int t = 0; t < 4; t++) begin
      k = rnd128(); iv = rnd128();
      do_init(k, iv, t == 1);
      do_absorb(rnd128());
    end

    // back-to-back accepted words
    msg_valid_i = 1'b1;
    for (int t = 0; t < 5; t++) begin
      m = rnd128(); msg_i = m;
      tick();
      ref_upd(m);
      chk(state_o == ref_flat() && done_o == 1'b1, "R7 back-to-back", state_o, ref_flat());
    end
    msg_valid_i = 1'b0;
    tick();

    // start and valid together: start wins, word waits until init ends
    k = rnd128(); iv = rnd128(); m = rnd128();
    key_i = k; iv_i = iv; start_i = 1'b1; msg_valid_i = 1'b1; msg_i = m;
    #1;
    chk(msg_ready_o == 1'b0, "R9 ready low with start", 640'(msg_ready_o), 640'(0));
    tick();
    start_i = 1'b0;
    ref_load(k, iv);
    chk(state_o == ref_flat(), "R9 load not absorb", state_o, ref_flat());
    for (int s = 1; s <= 10; s++) tick();
    for (int p = 0; p < 5; p++) begin
      ref_upd(k); ref_upd(k ^ iv);
    end
    chk(state_o == ref_flat() && done_o, "R6 word held off during init", state_o, ref_flat());
    tick();
    msg_valid_i = 1'b0;
    ref_upd(m);
    chk(state_o == ref_flat() && done_o, "R7 held word taken after init", state_o, ref_flat());
    tick();

    // reset in the middle of init
    key_i = rnd128(); start_i = 1'b1;
    tick();
    start_i = 1'b0;
    tick(); tick();
    rst_ni = 1'b0;
    #1;
    chk(state_o == '0 && done_o == 1'b0, "R1 reset mid-init", state_o, '0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk(state_o == '0 && msg_ready_o == 1'b1, "R1 idle after reset", 640'(msg_ready_o), 640'(1));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule